// File: doc/BRIEF.md
# Chip-Selected Serial Command/Data Receiver

This block is the write-only serial input port of a display controller. A host drives a serial clock, a serial data line, a data-or-command select line and a two-pin chip enable (one active-low, one active-high). While the chip is enabled, the block samples one bit on each rising serial clock edge, most significant bit first. On the rising edge that completes a word, it forms the parallel word. On that same edge it samples the select line to tag the word as display data or as a command.

Completed words cross into the core clock domain through a toggle handshake. The core sees the word and its tag on registered outputs, with a valid strobe that is high for exactly one core cycle per word. Dropping either enable pin at any time clears the partial word and the bit counter, so the next enabled edge starts a fresh word. A partial word produces nothing. Words may follow each other with no deselect between them. The port has no read path.

Top module: `scdr_top`

## Requirements
- R1: After reset, `word_valid_o` is 0, `word_o` is all zeros and `word_is_data_o` is 0.
- R2: Bits sampled on successive rising `ser_clk_i` edges fill the word from the most significant bit (first bit) to bit 0 (last bit), and the core receives that word.
- R3: `kind_i` is sampled only on the word's last rising serial edge; 1 sets `word_is_data_o` to 1 (display data), 0 sets it to 0 (command). Its level on earlier edges has no effect.
- R4: Each completed word raises `word_valid_o` for exactly one core clock cycle, and only once.
- R5: After a completed word the bit counter restarts, so back-to-back words need no deselect between them.
- R6: If `en_n_i` goes high or `en_i` goes low before the last edge of a word, that partial word yields no output, and the next word starts fresh at its most significant bit.
- R7: Serial clock edges while the chip is not enabled produce no word and leave `word_o`/`word_is_data_o` unchanged.
- R8: `word_o` and `word_is_data_o` keep their last delivered values between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| en_n_i | input | 1 | Active-low chip enable |
| en_i | input | 1 | Active-high chip enable |
| ser_clk_i | input | 1 | Serial clock, sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| kind_i | input | 1 | 1 = display data, 0 = command; sampled on the last edge |
| word_o | output | WORD_W | Last delivered word |
| word_is_data_o | output | 1 | Tag of the last delivered word |
| word_valid_o | output | 1 | One-cycle strobe per delivered word |

## Verification
The bench builds the block with its defaults: 8-bit words and a two-stage synchronizer. The serial clock runs five times slower than the core clock. These values place the handshake delay well inside one word time, so every completed word reaches the core before the next one overwrites the hold register. They also make mid-word aborts through either enable pin, back-to-back words and clocking while disabled all reachable with short, exact bit counts.

// File: rtl/scdr_pkg.sv
package scdr_pkg;

    typedef enum logic {
        KIND_CMD  = 1'b0,
        KIND_DATA = 1'b1
    } word_kind_e;

    localparam int unsigned DEF_WORD_W = 8;
    localparam int unsigned DEF_SYNC_N = 2;

endpackage

// File: rtl/scdr_shift.sv
module scdr_shift
    import scdr_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              ser_clk_i,
    input  logic              rst_n,
    input  logic              clr_n_i,
    input  logic              ser_dat_i,
    input  logic              kind_i,
    output logic [WORD_W-1:0] hold_word_o,
    output word_kind_e        hold_kind_o,
    output logic              hold_tog_o
);

    localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } asm_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        word_kind_e        kind;
        logic              tog;
    } hold_t;

    asm_t  asm_d, asm_q;
    hold_t hold_d, hold_q;
    logic  last_edge;
    logic [WORD_W-1:0] full_word;

    always_comb begin
        last_edge = (asm_q.cnt == LAST_BIT);
        full_word = {asm_q.sh[WORD_W-2:0], ser_dat_i};
        asm_d     = asm_q;
        hold_d    = hold_q;
        asm_d.sh  = full_word;
        asm_d.cnt = last_edge ? '0 : asm_q.cnt + 1'b1;
        if (last_edge) begin
            hold_d.word = full_word;
            hold_d.kind = word_kind_e'(kind_i);
            hold_d.tog  = ~hold_q.tog;
        end
    end

    // Assembly state is cleared whenever the chip is not enabled.
    always_ff @(posedge ser_clk_i or negedge clr_n_i) begin
        if (!clr_n_i) asm_q <= '0;
        else          asm_q <= asm_d;
    end

    // Completed words survive a deselect; only the core reset clears them.
    always_ff @(posedge ser_clk_i or negedge rst_n) begin
        if (!rst_n) hold_q <= '{word: '0, kind: KIND_CMD, tog: 1'b0};
        else        hold_q <= hold_d;
    end

    assign hold_word_o = hold_q.word;
    assign hold_kind_o = hold_q.kind;
    assign hold_tog_o  = hold_q.tog;

    // R5: the counter restarts after the last bit
    a_r5_cnt_wrap: assert property (@(posedge ser_clk_i) disable iff (!clr_n_i)
        (asm_q.cnt == LAST_BIT) |=> (asm_q.cnt == '0));

    // R6 / R7: no word is handed off except on the last bit
    a_r6_no_early_handoff: assert property (@(posedge ser_clk_i) disable iff (!clr_n_i || !rst_n)
        (asm_q.cnt != LAST_BIT) |=> $stable(hold_q.tog));

    // R3: tag follows the select level on the last edge
    a_r3_kind_capture: assert property (@(posedge ser_clk_i) disable iff (!clr_n_i || !rst_n)
        (asm_q.cnt == LAST_BIT) |=> (hold_q.kind == word_kind_e'($past(kind_i))));

endmodule

// File: rtl/scdr_sync.sv
module scdr_sync
    import scdr_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tog_i,
    input  logic [WORD_W-1:0] word_i,
    input  word_kind_e        kind_i,
    output logic [WORD_W-1:0] word_o,
    output logic              is_data_o,
    output logic              valid_o
);

    logic [SYNC_N-1:0] sync_q;

    generate
        for (genvar s = 0; s < SYNC_N; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tog_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    typedef struct packed {
        logic              seen;
        logic [WORD_W-1:0] word;
        logic              is_data;
        logic              valid;
    } core_t;

    core_t core_d, core_q;
    logic  tog_edge;

    always_comb begin
        tog_edge      = sync_q[SYNC_N-1] ^ core_q.seen;
        core_d        = core_q;
        core_d.seen   = sync_q[SYNC_N-1];
        core_d.valid  = tog_edge;
        if (tog_edge) begin
            core_d.word    = word_i;
            core_d.is_data = (kind_i == KIND_DATA);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign word_o    = core_q.word;
    assign is_data_o = core_q.is_data;
    assign valid_o   = core_q.valid;

    // R4: the strobe never lasts two cycles
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: outputs hold between strobes
    a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(word_o) && $stable(is_data_o)));

endmodule

// File: rtl/scdr_top.sv
module scdr_top
    import scdr_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n_i,
    input  logic              en_i,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              kind_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_is_data_o,
    output logic              word_valid_o
);

    logic              enabled;
    logic              clr_n;
    logic [WORD_W-1:0] hold_word;
    word_kind_e        hold_kind;
    logic              hold_tog;

    assign enabled = !en_n_i && en_i;
    assign clr_n   = rst_n && enabled;

    scdr_shift #(.WORD_W(WORD_W)) u_shift (
        .ser_clk_i   (ser_clk_i),
        .rst_n       (rst_n),
        .clr_n_i     (clr_n),
        .ser_dat_i   (ser_dat_i),
        .kind_i      (kind_i),
        .hold_word_o (hold_word),
        .hold_kind_o (hold_kind),
        .hold_tog_o  (hold_tog)
    );

    scdr_sync #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tog_i     (hold_tog),
        .word_i    (hold_word),
        .kind_i    (hold_kind),
        .word_o    (word_o),
        .is_data_o (word_is_data_o),
        .valid_o   (word_valid_o)
    );

    // R1: reset leaves the strobe low
    a_r1_reset_quiet: assert property (@(posedge clk) $rose(rst_n) |-> !word_valid_o);

endmodule

// File: tb/scdr_top_tb_top.sv
module scdr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       en = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       kind = 1'b0;
    logic [7:0] word;
    logic       is_data;
    logic       valid;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] w;
        logic       k;
        int         req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    scdr_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_n_i         (en_n),
        .en_i           (en),
        .ser_clk_i      (ser_clk),
        .ser_dat_i      (ser_dat),
        .kind_i         (kind),
        .word_o         (word),
        .word_is_data_o (is_data),
        .word_valid_o   (valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Clock n bits of b from the top; earlier edges see the opposite select level.
    task automatic shift_bits(input logic [7:0] b, input int n, input logic k);
        for (int i = 7; i > 7 - n; i--) begin
            ser_dat = b[i];
            kind    = (i == 0) ? k : ~k;
            #20 ser_clk = 1'b1;
            #20 ser_clk = 1'b0;
        end
    endtask

    task automatic send_word(input logic [7:0] b, input logic k, input int req);
        q.push_back('{w: b, k: k, req: req});
        shift_bits(b, 8, k);
    endtask

    // Scoreboard monitor
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid && prev_valid)
                check(1'b0, "R4 strobe wider than one cycle", 1, 0);
            if (valid && !prev_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6/R7 unexpected word", int'(word), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(word == e.w, $sformatf("R%0d word", e.req), int'(word), int'(e.w));
                    // R3 tag from last-edge select level
                    check(is_data == e.k, "R3 tag", int'(is_data), int'(e.k));
                end
            end
            prev_valid <= valid;
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] last_w;
        logic       last_k;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(valid == 1'b0, "R1 valid", int'(valid), 0);
        check(word == 8'h00, "R1 word", int'(word), 0);
        check(is_data == 1'b0, "R1 tag", int'(is_data), 0);
        rst_n = 1'b1;
        #40;
        en_n = 1'b0;
        #40;
        // R2 MSB-first assembly, display data and command tags
        send_word(8'hA5, 1'b1, 2);
        send_word(8'h3C, 1'b0, 2);
        // R5 back-to-back, no deselect
        send_word(8'h81, 1'b1, 5);
        send_word(8'h7E, 1'b0, 5);
        send_word(8'hFF, 1'b1, 5);
        #200;
        // R6 abort via active-low enable
        shift_bits(8'hF0, 5, 1'b1);
        en_n = 1'b1;
        #60;
        en_n = 1'b0;
        #40;
        send_word(8'h12, 1'b0, 6);
        #200;
        // R6 abort via active-high enable
        shift_bits(8'h0F, 7, 1'b0);
        en = 1'b0;
        #60;
        en = 1'b1;
        #40;
        send_word(8'hC3, 1'b1, 6);
        #400;
        last_w = word;
        last_k = is_data;
        // R7 clocks while disabled are ignored
        en_n = 1'b1;
        shift_bits(8'h55, 8, 1'b0);
        shift_bits(8'hAA, 8, 1'b1);
        en_n = 1'b0;
        #400;
        check(word == last_w, "R7 word unchanged", int'(word), int'(last_w));
        check(is_data == last_k, "R8 tag held", int'(is_data), int'(last_k));
        #40;
        // R6 fresh alignment after disabled clocks
        send_word(8'h69, 1'b0, 6);
        #400;
        check(q.size() == 0, "R4/R6 all words delivered once", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule